// File: doc/BRIEF.md
# Twelve-Clock Framed SPI Byte Slave

This block is a serial slave that moves exactly one byte per chip-select window using a fixed frame of twelve serial clocks. Each frame opens with a start bit. Two setup bits follow: a direction bit and a target bit. Then come eight data bits, most significant first. In the last clock the slave returns one status bit that tells the master whether the transfer took effect. A byte written by the master lands in a receive FIFO. A byte read by the master comes from the head of a transmit FIFO. A separate target selects a two-flag status byte instead of the data path.

On the system side the block offers a show-ahead pop port for the receive FIFO and a push port for the transmit FIFO, with empty and full flags for both. The serial clock, select and data input are brought into the system clock by synchronisers, and all framing runs on the detected edges. The system clock must therefore run several times faster than the serial clock.

Top module: `spi12_slave`

## Requirements
- R1: A frame is twelve serial clocks: start bit (must be 1), direction, target, eight data bits sent most significant bit first, then one status bit. MOSI is sampled on rising SCLK and MISO changes only on falling SCLK.
- R2: Direction 0 with target 0 is a data write: the eight data bits are pushed into the receive FIFO when the twelfth rising edge arrives, and the status bit is 0.
- R3: A data write while the receive FIFO is full is discarded, the FIFO is unchanged, and the status bit is 1.
- R4: Direction 1 with target 0 is a data read: MISO carries the transmit FIFO head during the data bits, the entry is popped at the twelfth rising edge, and the status bit is 0.
- R5: A data read while the transmit FIFO is empty returns the last byte popped by a successful read (0x00 after reset), pops nothing, and returns status bit 1.
- R6: Direction 1 with target 1 returns the status byte in the data bits: bit 0 is receive-FIFO full, bit 1 is transmit-FIFO empty, bits 7..2 are 0. The status bit is 0 and neither FIFO changes.
- R7: Direction 0 with target 1 has no effect on either FIFO, and the status bit is 0.
- R8: Chip select (active high) falling at any point in a frame aborts it: no push, no pop, and the next frame is decoded from its start bit.
- R9: A frame whose first sampled bit is 0 is ignored until chip select falls, and MISO stays 0 for that frame.
- R10: MISO is 0 whenever chip select is low and during the start and setup bits. MISO is 0 during the data bits of write frames.
- R11: The system side pushes the transmit FIFO with tx_push (ignored when tx_full) and pops the receive FIFO with rx_pop (ignored when rx_empty). rx_data shows the oldest entry before the pop.
- R12: After reset both FIFOs are empty (rx_empty=1, tx_empty=1, both full flags 0) and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idles low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data and status bit to the master |
| rx_pop | input | 1 | Pop the receive FIFO |
| rx_data | output | 8 | Oldest receive FIFO entry |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| tx_push | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | 8 | Byte to queue for the master |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |

## Verification
The bound checker watches every cycle for properties that need no scenario. The engine never pushes into a full receive FIFO and never pops an empty transmit FIFO. Each frame commits at most one byte. MISO moves only on a falling serial edge or when select drops, and it goes quiet while select is low. No FIFO ever reports empty and full together. The bench scenarios cover the parts that depend on frame content. These are the bit order of returned bytes, the repeated stale byte on an empty read, the retry status on a full write, the contents of the status byte, and the absence of side effects from aborted frames, zero-start frames and target-1 writes. They can only be shown by running whole frames and then reading the FIFOs back through their ports.

// File: rtl/spi12_pkg.sv
package spi12_pkg;

    localparam int BYTE_W     = 8;
    localparam int CNT_W      = 4;

    // bit positions inside a frame, counted from the start bit
    localparam logic [CNT_W-1:0] POS_DIR  = 4'd1;
    localparam logic [CNT_W-1:0] POS_TGT  = 4'd2;
    localparam logic [CNT_W-1:0] POS_MSB  = 4'd3;
    localparam logic [CNT_W-1:0] POS_LSB  = 4'd10;
    localparam logic [CNT_W-1:0] POS_STAT = 4'd11;

    // status byte field positions
    localparam int SB_RX_FULL  = 0;
    localparam int SB_TX_EMPTY = 1;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_RUN  = 2'd1,
        FR_SKIP = 2'd2
    } frame_st_e;

endpackage

// File: rtl/spi12_sync.sv
module spi12_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out,
    output logic [WIDTH-1:0] rise_out,
    output logic [WIDTH-1:0] fall_out
);

    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_in;
        for (int i = 1; i <= STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_out    = pipe_q[STAGES-1];
    assign rise_out = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_out = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/spi12_fifo.sv
module spi12_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t d, q;
    logic  do_push, do_pop;

    function automatic logic [AW-1:0] next_slot(input logic [AW-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != FULL_CNT);
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wr] = wdata;
            d.wr        = next_slot(q.wr);
        end
        if (do_pop) begin
            d.rd = next_slot(q.rd);
        end
        if (do_push && !do_pop) begin
            d.cnt = q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.mem[q.rd];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == FULL_CNT);

endmodule

// File: rtl/spi12_frame.sv
module spi12_frame
    import spi12_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mosi_i,
    input  logic [BYTE_W-1:0] tx_head,
    input  logic              tx_empty,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_wdata,
    output logic              tx_pop,
    output logic              miso
);

    typedef struct packed {
        frame_st_e         st;
        logic [CNT_W-1:0]  cnt;
        logic              dir;
        logic              tgt;
        logic              stale;
        logic              stat;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] last;
        logic              miso;
    } frame_t;

    frame_t            d, q;
    logic [CNT_W-1:0]  idx;
    logic [BYTE_W-1:0] status_byte;
    logic              stat_bit;

    always_comb begin
        status_byte              = '0;
        status_byte[SB_RX_FULL]  = rx_full;
        status_byte[SB_TX_EMPTY] = tx_empty;
    end

    always_comb begin
        d        = q;
        rx_push  = 1'b0;
        tx_pop   = 1'b0;
        idx      = POS_LSB - q.cnt;
        stat_bit = !q.tgt && (q.dir ? q.stale : rx_full);
        if (!cs_i) begin
            d.st   = FR_IDLE;
            d.cnt  = '0;
            d.miso = 1'b0;
        end else if (rise_i) begin
            unique case (q.st)
                FR_IDLE: begin
                    if (mosi_i) begin
                        d.st  = FR_RUN;
                        d.cnt = POS_DIR;
                    end else begin
                        d.st = FR_SKIP;
                    end
                end
                FR_RUN: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == POS_DIR) begin
                        d.dir = mosi_i;
                    end else if (q.cnt == POS_TGT) begin
                        d.tgt   = mosi_i;
                        d.stale = 1'b0;
                        d.shreg = '0;
                        if (q.dir) begin
                            if (mosi_i) begin
                                d.shreg = status_byte;
                            end else if (tx_empty) begin
                                d.shreg = q.last;
                                d.stale = 1'b1;
                            end else begin
                                d.shreg = tx_head;
                            end
                        end
                    end else if (q.cnt == POS_STAT) begin
                        if (!q.tgt && !q.stat) begin
                            if (q.dir) begin
                                tx_pop = 1'b1;
                                d.last = q.shreg;
                            end else begin
                                rx_push = 1'b1;
                            end
                        end
                        d.st = FR_SKIP;
                    end else if (!q.dir) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], mosi_i};
                    end
                end
                default: ;
            endcase
        end else if (fall_i && q.st == FR_RUN) begin
            if (q.cnt == POS_STAT) begin
                d.stat = stat_bit;
                d.miso = stat_bit;
            end else if (q.cnt >= POS_MSB) begin
                d.miso = q.dir & q.shreg[idx[2:0]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: FR_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rx_wdata = q.shreg;
    assign miso     = q.miso;

endmodule

// File: rtl/spi12_slave.sv
module spi12_slave
    import spi12_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              rx_full,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_empty,
    output logic              tx_full
);

    localparam int IDX_SCLK = 0;
    localparam int IDX_CS   = 1;
    localparam int IDX_MOSI = 2;

    logic [2:0]        pins_q, pins_rise, pins_fall;
    logic              cs_s, sclk_rise, sclk_fall, mosi_s;
    logic              eng_rx_push, eng_tx_pop;
    logic [BYTE_W-1:0] eng_rx_wdata, tx_head;

    spi12_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_in     ({spi_mosi, spi_cs, spi_sclk}),
        .q_out    (pins_q),
        .rise_out (pins_rise),
        .fall_out (pins_fall)
    );

    assign cs_s      = pins_q[IDX_CS];
    assign mosi_s    = pins_q[IDX_MOSI];
    assign sclk_rise = pins_rise[IDX_SCLK];
    assign sclk_fall = pins_fall[IDX_SCLK];

    spi12_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_i     (cs_s),
        .rise_i   (sclk_rise),
        .fall_i   (sclk_fall),
        .mosi_i   (mosi_s),
        .tx_head  (tx_head),
        .tx_empty (tx_empty),
        .rx_full  (rx_full),
        .rx_push  (eng_rx_push),
        .rx_wdata (eng_rx_wdata),
        .tx_pop   (eng_tx_pop),
        .miso     (spi_miso)
    );

    spi12_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (eng_rx_push),
        .wdata (eng_rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_data),
        .empty (rx_empty),
        .full  (rx_full)
    );

    spi12_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (tx_data),
        .pop   (eng_tx_pop),
        .rdata (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

endmodule

// File: rtl/spi12_checks.sv
module spi12_checks (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sclk_fall,
    input logic miso,
    input logic rx_push,
    input logic tx_pop,
    input logic rx_empty,
    input logic rx_full,
    input logic tx_empty,
    input logic tx_full
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    p_one_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    p_one_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop);

    p_miso_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !miso);

    p_miso_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> ($past(sclk_fall) || !$past(cs_s)));

    p_flags_sane_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty && rx_full) && !(tx_empty && tx_full));

endmodule

bind spi12_slave spi12_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .sclk_fall (sclk_fall),
    .miso      (spi_miso),
    .rx_push   (eng_rx_push),
    .tx_pop    (eng_tx_pop),
    .rx_empty  (rx_empty),
    .rx_full   (rx_full),
    .tx_empty  (tx_empty),
    .tx_full   (tx_full)
);

// File: tb/spi12_slave_bench.sv
`timescale 1ns/1ps
module spi12_slave_bench;

    localparam int HALF = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso;
    logic       rx_pop = 1'b0, tx_push = 1'b0;
    logic [7:0] rx_data, tx_data = 8'h00;
    logic       rx_empty, rx_full, tx_empty, tx_full;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi12_slave u_spi12_slave (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs(spi_cs), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .rx_full(rx_full),
        .tx_push(tx_push), .tx_data(tx_data), .tx_empty(tx_empty), .tx_full(tx_full)
    );

    // vector: {dir, tgt, byte_in[7:0], byte_out[7:0], status}
    localparam int NV = 12;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b1, 8'h00, 8'h00, 1'b0},  // R6 status: nothing full, tx not empty
        {1'b0, 1'b0, 8'h11, 8'h00, 1'b0},  // R2 write
        {1'b1, 1'b0, 8'h00, 8'hA5, 1'b0},  // R4 read head
        {1'b1, 1'b0, 8'h00, 8'h3C, 1'b0},  // R4 read next
        {1'b1, 1'b0, 8'h00, 8'h3C, 1'b1},  // R5 empty read repeats last
        {1'b1, 1'b1, 8'h00, 8'h02, 1'b0},  // R6 tx empty flag
        {1'b0, 1'b1, 8'hFF, 8'h00, 1'b0},  // R7 no effect
        {1'b0, 1'b0, 8'h22, 8'h00, 1'b0},  // R2
        {1'b0, 1'b0, 8'h33, 8'h00, 1'b0},  // R2
        {1'b0, 1'b0, 8'h44, 8'h00, 1'b0},  // R2 fills rx
        {1'b1, 1'b1, 8'h00, 8'h03, 1'b0},  // R6 both flags
        {1'b0, 1'b0, 8'h55, 8'h00, 1'b1}   // R3 write to full rx
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input bit start, input bit dir, input bit tgt,
                        input logic [7:0] din, input int nbits,
                        output logic [7:0] dout, output bit st, output bit any_hi);
        dout = 8'h00; st = 1'b0; any_hi = 1'b0;
        spi_cs = 1'b1;
        #(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (i == 0) spi_mosi = start;
            else if (i == 1) spi_mosi = dir;
            else if (i == 2) spi_mosi = tgt;
            else if (i <= 10) spi_mosi = din[10-i];
            else spi_mosi = 1'b0;
            #(HALF);
            if (spi_miso) any_hi = 1'b1;
            if (i >= 3 && i <= 10) dout[10-i] = spi_miso;
            if (i == 11) st = spi_miso;
            spi_sclk = 1'b1;
            #(HALF);
            spi_sclk = 1'b0;
        end
        #(HALF);
        spi_cs = 1'b0;
        spi_mosi = 1'b0;
        #(4*HALF);
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        tx_data = b;
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_rx_expect(input logic [7:0] exp, input string req);
        @(negedge clk);
        chk(!rx_empty && rx_data == exp, req, "rx data", rx_data, exp);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    initial begin
        #500us;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] dout;
        bit st, hi;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R12 reset state
        chk(rx_empty && !rx_full, "R12", "rx flags", {rx_empty, rx_full}, 2'b10);
        chk(tx_empty && !tx_full, "R12", "tx flags", {tx_empty, tx_full}, 2'b10);
        chk(spi_miso == 1'b0, "R12", "miso", spi_miso, 0);

        // R11 queue bytes for the master
        push_tx(8'hA5);
        push_tx(8'h3C);
        @(negedge clk);
        chk(!tx_empty, "R11", "tx not empty after push", tx_empty, 0);

        for (int v = 0; v < NV; v++) begin
            xfer(1'b1, VEC[v][18], VEC[v][17], VEC[v][16:9], 12, dout, st, hi);
            chk(dout == VEC[v][8:1], "R1", $sformatf("vec %0d byte", v), dout, VEC[v][8:1]);
            chk(st == VEC[v][0], "R2", $sformatf("vec %0d status", v), st, VEC[v][0]);
        end

        // R3: 0x55 was dropped; R7: 0xFF never stored; R11 show-ahead pops
        pop_rx_expect(8'h11, "R2");
        pop_rx_expect(8'h22, "R2");
        pop_rx_expect(8'h33, "R7");
        pop_rx_expect(8'h44, "R3");
        @(negedge clk);
        chk(rx_empty, "R3", "rx empty after four pops", rx_empty, 1);
        // R11 pop on empty is ignored
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        @(negedge clk);
        chk(rx_empty && !rx_full, "R11", "pop on empty", {rx_empty, rx_full}, 2'b10);

        // R8 abort a write after seven clocks
        xfer(1'b1, 1'b0, 1'b0, 8'h99, 7, dout, st, hi);
        chk(rx_empty, "R8", "aborted write stored nothing", rx_empty, 1);
        push_tx(8'h77);
        // R8 abort a read after nine clocks
        xfer(1'b1, 1'b1, 1'b0, 8'h00, 9, dout, st, hi);
        @(negedge clk);
        chk(!tx_empty, "R8", "aborted read popped nothing", tx_empty, 0);
        xfer(1'b1, 1'b1, 1'b0, 8'h00, 12, dout, st, hi);
        chk(dout == 8'h77 && st == 1'b0, "R8", "read after abort",
            {dout, st}, {8'h77, 1'b0});
        @(negedge clk);
        chk(tx_empty, "R4", "read popped", tx_empty, 1);

        // R9 zero start bit: frame carrying a write is ignored
        xfer(1'b0, 1'b0, 1'b0, 8'h66, 12, dout, st, hi);
        chk(!hi, "R9", "miso quiet", hi, 0);
        chk(rx_empty, "R9", "no push", rx_empty, 1);
        // R9 zero start with read setup bits: no pop, no data
        push_tx(8'h5A);
        xfer(1'b0, 1'b1, 1'b0, 8'h00, 12, dout, st, hi);
        @(negedge clk);
        chk(!hi && !tx_empty, "R9", "ignored read", {hi, tx_empty}, 2'b00);
        xfer(1'b1, 1'b1, 1'b0, 8'h00, 12, dout, st, hi);
        chk(dout == 8'h5A && !st, "R4", "read 5A", {dout, st}, {8'h5A, 1'b0});

        // R10 write frame keeps miso low through the data bits
        xfer(1'b1, 1'b0, 1'b0, 8'hFF, 12, dout, st, hi);
        chk(!hi, "R10", "miso low on write", hi, 0);
        pop_rx_expect(8'hFF, "R10");

        // R11 tx full: fifth push ignored
        for (int k = 1; k <= 4; k++) push_tx(8'(k));
        @(negedge clk);
        chk(tx_full, "R11", "tx full", tx_full, 1);
        push_tx(8'h05);
        for (int k = 1; k <= 4; k++) begin
            xfer(1'b1, 1'b1, 1'b0, 8'h00, 12, dout, st, hi);
            chk(dout == 8'(k) && !st, "R11", "drain", {dout, st}, {8'(k), 1'b0});
        end
        // R5 stale read repeats last sent byte, 0x05 never queued
        xfer(1'b1, 1'b1, 1'b0, 8'h00, 12, dout, st, hi);
        chk(dout == 8'h04 && st, "R5", "stale repeat", {dout, st}, {8'h04, 1'b1});
        chk(spi_miso == 1'b0, "R10", "miso after cs low", spi_miso, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule